// File: doc/BRIEF.md
# Ethernet IPv4 Receive Header Parser

This block sits behind a receive MAC. It takes a frame as a stream of 32-bit words, with the first byte on the wire in bits [31:24]. Each accepted word goes straight to the write port of an external buffer that holds one frame. The block does not wait for header decoding before writing. In the same cycles it decodes the Ethernet type field and, for IPv4 frames, the IPv4, TCP and UDP headers, and it accumulates the IPv4 header checksum.

When the last word arrives, the block either publishes one packet-information record or rejects the frame. The record holds a protocol code, the IP header length, the layer-4 header length and the payload length. A frame is rejected when its IPv4 header checksum is wrong. A rejected frame pulses an error strobe toward the downstream descriptor processor and a flush strobe toward the buffer, and it leaves the record empty.

Only one frame can be held at a time. The consumer frees the buffer with a release strobe. A frame that starts while the buffer is still held is discarded, and a sticky overflow flag is set.

Top module: `eth_rx_hdr_parser`

## Requirements
- R1: Every accepted input word drives `fifo_wr_en` high in the same cycle. `fifo_wr_data` equals the input word, and `fifo_wr_addr` is the word position counted from 0 at the word flagged `in_sof`.
- R2: `info_proto` is set from the 16-bit type field in frame bytes 12-13. Type 0x0800 is IPv4, 0x0806 gives code 1 and 0x8035 gives code 2, and any other type gives code 0. For IPv4 the code comes from the protocol byte (frame byte 23): 6 gives code 4, 17 gives code 5, and any other value gives code 3.
- R3: For IPv4, `info_ip_hlen` is four times the header-length nibble, which is the low nibble of frame byte 14.
- R4: For TCP, `info_l4_hlen` is four times the data-offset nibble (upper nibble of TCP header byte 12), and `info_data_len` is the IP total length (frame bytes 16-17) minus both header lengths. For UDP, `info_l4_hlen` is 8 and `info_data_len` is the UDP length field (UDP header bytes 4-5) minus 8. For any other IPv4 protocol, `info_l4_hlen` is 0 and `info_data_len` is the total length minus the IP header length.
- R5: A frame that is not IPv4 is accepted with no checksum test, and all three length fields are zero.
- R6: The IPv4 header checksum is the 16-bit ones'-complement sum, with end-around carry, over the header-length-times-4 bytes from frame byte 14; the header is valid when the sum is 0xFFFF. A bad sum makes `csum_err` and `fifo_flush` high for exactly the one cycle after the last word, and it leaves `info_valid` low with every field zero.
- R7: A good frame sets `info_valid` and its fields one cycle after its last word. They hold unchanged until `pkt_release`, which clears `info_valid` and every field to zero on the next cycle.
- R8: A frame whose first word arrives while `info_valid` is high, with `pkt_release` low in that cycle, is dropped in whole: no word is written and the held record does not change.
- R9: A dropped frame sets `ovf_flag`, which then stays high until reset.
- R10: When `pkt_release` and the first word of a frame arrive in the same cycle, that frame is accepted and written from address 0.
- R11: After reset all outputs are low or zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input word present |
| in_sof | input | 1 | Word is the first of a frame |
| in_eof | input | 1 | Word is the last of a frame |
| in_data | input | 32 | Frame word, earliest byte in bits [31:24] |
| pkt_release | input | 1 | Consumer frees the held frame and record |
| fifo_wr_en | output | 1 | Buffer write strobe |
| fifo_wr_addr | output | $clog2(FIFO_WORDS) | Buffer word address |
| fifo_wr_data | output | 32 | Buffer write data |
| fifo_flush | output | 1 | Discard buffer contents |
| info_valid | output | 1 | Record holds a frame |
| info_proto | output | 3 | Protocol code |
| info_ip_hlen | output | 6 | IPv4 header length in bytes |
| info_l4_hlen | output | 6 | TCP/UDP header length in bytes |
| info_data_len | output | LEN_W | Layer-4 payload length in bytes |
| csum_err | output | 1 | Checksum failure strobe to the descriptor processor |
| ovf_flag | output | 1 | Sticky: a frame was dropped while the buffer was held |

## Verification
The release of the held record and the start of a new frame can fall in the same cycle. The bench provokes this by raising `pkt_release` together with the first word of a frame. It expects that frame to be written from address 0 and its record published, with `ovf_flag` unchanged. A second overlap is the end of a frame together with the checksum decision: the word carrying the last header halfword and the final fold happen in one cycle. The bench provokes this with maximum-length headers and corrupted checksums, and it judges the outcome from the strobes and the record one cycle later.

// File: rtl/eth_rx_hdr_parser.sv
module eth_rx_hdr_parser #(
  parameter int FIFO_WORDS = 380,
  parameter int LEN_W      = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic                          in_sof,
  input  logic                          in_eof,
  input  logic [31:0]                   in_data,
  input  logic                          pkt_release,
  output logic                          fifo_wr_en,
  output logic [$clog2(FIFO_WORDS)-1:0] fifo_wr_addr,
  output logic [31:0]                   fifo_wr_data,
  output logic                          fifo_flush,
  output logic                          info_valid,
  output logic [2:0]                    info_proto,
  output logic [5:0]                    info_ip_hlen,
  output logic [5:0]                    info_l4_hlen,
  output logic [LEN_W-1:0]              info_data_len,
  output logic                          csum_err,
  output logic                          ovf_flag
);
  localparam int AW = $clog2(FIFO_WORDS);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] I_TYPE = CW'(3);
  localparam logic [CW-1:0] I_TOT  = CW'(4);
  localparam logic [CW-1:0] I_PROT = CW'(5);
  localparam logic [CW-1:0] I_TCP  = CW'(6);
  localparam logic [2:0] P_OTHER = 3'd0, P_ARP = 3'd1, P_RARP = 3'd2,
                         P_IP = 3'd3, P_TCP = 3'd4, P_UDP = 3'd5;

  logic [CW-1:0] cnt, idx, ihl_x;
  logic          in_frame, drop_r, busy_eff, accept;
  logic [15:0]   type_r, tot_r, udp_r, type_eff;
  logic [3:0]    ihl_r, doff_r, ihl_eff;
  logic [7:0]    prot_r;
  logic [21:0]   acc, acc_base, acc_next;
  logic [CW:0]   hw_up, hw_lo, hw_end;
  logic          up_in, lo_in, is_ip, sum_ok;
  logic [16:0]   fold1;
  logic [15:0]   fold2;
  logic [5:0]    ip_hl, tcp_hl;

  assign busy_eff = info_valid & ~pkt_release;
  assign accept   = in_valid & (in_sof ? ~busy_eff : (in_frame & ~drop_r));
  assign idx      = in_sof ? '0 : cnt;
  assign ihl_x    = {{(CW-4){1'b0}}, ihl_r};
  assign ihl_eff  = (idx == I_TYPE) ? in_data[11:8] : ihl_r;
  assign type_eff = (idx == I_TYPE) ? in_data[31:16] : ((idx < I_TYPE) ? 16'h0 : type_r);

  assign fifo_wr_en   = accept && (idx < CW'(FIFO_WORDS));
  assign fifo_wr_addr = idx[AW-1:0];
  assign fifo_wr_data = in_data;

  assign hw_up  = {idx, 1'b0};
  assign hw_lo  = {idx, 1'b1};
  assign hw_end = (CW+1)'(7) + {{(CW-4){1'b0}}, ihl_eff, 1'b0};
  assign up_in  = (hw_up >= (CW+1)'(7)) && (hw_up < hw_end);
  assign lo_in  = (hw_lo >= (CW+1)'(7)) && (hw_lo < hw_end);
  assign acc_base = in_sof ? '0 : acc;
  assign acc_next = acc_base + (up_in ? {6'd0, in_data[31:16]} : 22'd0)
                             + (lo_in ? {6'd0, in_data[15:0]}  : 22'd0);
  assign fold1  = {1'b0, acc_next[15:0]} + {11'd0, acc_next[21:16]};
  assign fold2  = fold1[15:0] + {15'd0, fold1[16]};
  assign sum_ok = (fold2 == 16'hFFFF);
  assign is_ip  = (type_eff == 16'h0800);
  assign ip_hl  = {ihl_r, 2'b00};
  assign tcp_hl = {doff_r, 2'b00};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; in_frame <= 1'b0; drop_r <= 1'b0;
      type_r <= '0; tot_r <= '0; udp_r <= '0; ihl_r <= '0; doff_r <= '0; prot_r <= '0;
      acc <= '0;
      info_valid <= 1'b0; info_proto <= '0; info_ip_hlen <= '0; info_l4_hlen <= '0;
      info_data_len <= '0; csum_err <= 1'b0; fifo_flush <= 1'b0; ovf_flag <= 1'b0;
    end else begin
      csum_err   <= 1'b0;
      fifo_flush <= 1'b0;
      if (in_valid && in_sof && busy_eff) ovf_flag <= 1'b1;
      if (pkt_release) begin
        info_valid <= 1'b0; info_proto <= '0; info_ip_hlen <= '0;
        info_l4_hlen <= '0; info_data_len <= '0;
      end
      if (in_valid && in_sof) begin
        drop_r   <= busy_eff;
        in_frame <= ~in_eof;
      end else if (in_valid && in_frame && in_eof) begin
        in_frame <= 1'b0;
      end
      if (accept) begin
        cnt <= idx + CW'(1);
        acc <= acc_next;
        if (in_sof) type_r <= '0;
        if (idx == I_TYPE) begin
          type_r <= in_data[31:16];
          ihl_r  <= in_data[11:8];
        end
        if (idx == I_TOT)  tot_r  <= in_data[31:16];
        if (idx == I_PROT) prot_r <= in_data[7:0];
        if (idx > I_PROT && idx == I_TOT + ihl_x) udp_r  <= in_data[15:0];
        if (idx > I_PROT && idx == I_TCP + ihl_x) doff_r <= in_data[15:12];
        if (in_eof) begin
          if (is_ip && !sum_ok) begin
            csum_err <= 1'b1; fifo_flush <= 1'b1;
            info_valid <= 1'b0; info_proto <= '0; info_ip_hlen <= '0;
            info_l4_hlen <= '0; info_data_len <= '0;
          end else if (is_ip) begin
            info_valid   <= 1'b1;
            info_ip_hlen <= ip_hl;
            case (prot_r)
              8'd6: begin
                info_proto    <= P_TCP;
                info_l4_hlen  <= tcp_hl;
                info_data_len <= LEN_W'(tot_r) - LEN_W'(ip_hl) - LEN_W'(tcp_hl);
              end
              8'd17: begin
                info_proto    <= P_UDP;
                info_l4_hlen  <= 6'd8;
                info_data_len <= LEN_W'(udp_r) - LEN_W'(8);
              end
              default: begin
                info_proto    <= P_IP;
                info_l4_hlen  <= '0;
                info_data_len <= LEN_W'(tot_r) - LEN_W'(ip_hl);
              end
            endcase
          end else begin
            info_valid    <= 1'b1;
            info_ip_hlen  <= '0;
            info_l4_hlen  <= '0;
            info_data_len <= '0;
            case (type_eff)
              16'h0806: info_proto <= P_ARP;
              16'h8035: info_proto <= P_RARP;
              default:  info_proto <= P_OTHER;
            endcase
          end
        end
      end
    end
  end

  AST_ERR_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    csum_err |-> (fifo_flush && !info_valid && info_data_len == '0)); // R6
  AST_BUSY_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (info_valid && !pkt_release) |-> !fifo_wr_en); // R8
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag |=> ovf_flag); // R9
  AST_INFO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (info_valid && !pkt_release) |=> (info_valid && $stable(info_proto) && $stable(info_data_len))); // R7
  AST_RELEASE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_release && !in_valid) |=> !info_valid); // R7
  AST_NONIP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (info_valid && info_proto < 3'd3) |-> (info_ip_hlen == '0 && info_data_len == '0)); // R5
endmodule

// File: tb/eth_rx_hdr_parser_bench.sv
`timescale 1ns/1ps
module eth_rx_hdr_parser_bench;
  localparam int CLKP = 8;
  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_sof = 0, in_eof = 0, pkt_release = 0;
  logic [31:0] in_data = 0;
  logic fifo_wr_en, fifo_flush, info_valid, csum_err, ovf_flag;
  logic [8:0] fifo_wr_addr;
  logic [31:0] fifo_wr_data;
  logic [2:0] info_proto;
  logic [5:0] info_ip_hlen, info_l4_hlen;
  logic [15:0] info_data_len;

  eth_rx_hdr_parser u_eth_rx_hdr_parser (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
    .in_data(in_data), .pkt_release(pkt_release), .fifo_wr_en(fifo_wr_en),
    .fifo_wr_addr(fifo_wr_addr), .fifo_wr_data(fifo_wr_data), .fifo_flush(fifo_flush),
    .info_valid(info_valid), .info_proto(info_proto), .info_ip_hlen(info_ip_hlen),
    .info_l4_hlen(info_l4_hlen), .info_data_len(info_data_len), .csum_err(csum_err),
    .ovf_flag(ovf_flag));

  always #(CLKP/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] fb [0:1599];
  int nbytes;
  bit e_ip, e_bad;
  int e_proto, e_iph, e_l4h, e_dlen;

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  function automatic int rnd(int lo, int hi);
    return lo + int'($urandom % (hi - lo + 1));
  endfunction

  task automatic clear_fb();
    for (int i = 0; i < 1600; i++) fb[i] = 8'h00;
  endtask

  task automatic build_raw(int typ, int len);
    clear_fb();
    for (int i = 0; i < len; i++) fb[i] = 8'($urandom);
    fb[12] = 8'(typ >> 8); fb[13] = 8'(typ);
    nbytes = len;
    e_ip = 0; e_bad = 0; e_iph = 0; e_l4h = 0; e_dlen = 0;
    e_proto = (typ == 16'h0806) ? 1 : (typ == 16'h8035) ? 2 : 0;
  endtask

  task automatic build_ip(int ihl, int prot, int doff, int plen, bit bad);
    int o, l4h, tot, sum;
    clear_fb();
    for (int i = 0; i < 12; i++) fb[i] = 8'($urandom);
    fb[12] = 8'h08; fb[13] = 8'h00;
    l4h = (prot == 6) ? doff * 4 : (prot == 17) ? 8 : 0;
    tot = ihl * 4 + l4h + plen;
    for (int i = 14; i < 14 + tot; i++) fb[i] = 8'($urandom);
    fb[14] = 8'(8'h40 | ihl); fb[16] = 8'(tot >> 8); fb[17] = 8'(tot);
    fb[23] = 8'(prot); fb[24] = 0; fb[25] = 0;
    o = 14 + ihl * 4;
    if (prot == 6) fb[o + 12] = 8'(doff << 4);
    if (prot == 17) begin fb[o + 4] = 8'((8 + plen) >> 8); fb[o + 5] = 8'(8 + plen); end
    sum = 0;
    for (int h = 0; h < ihl * 2; h++) sum += {fb[14 + 2*h], fb[15 + 2*h]};
    while (sum > 16'hFFFF) sum = (sum & 16'hFFFF) + (sum >> 16);
    sum = ~sum & 16'hFFFF;
    fb[24] = 8'(sum >> 8); fb[25] = 8'(sum);
    if (bad) fb[25] = fb[25] ^ 8'h01;
    nbytes = (14 + tot < 60) ? 60 : 14 + tot;
    e_ip = 1; e_bad = bad; e_iph = ihl * 4; e_l4h = l4h; e_dlen = plen;
    e_proto = (prot == 6) ? 4 : (prot == 17) ? 5 : 3;
  endtask

  task automatic send_frame(bit rel_first, bit exp_acc);
    int nw;
    logic [31:0] w;
    nw = (nbytes + 3) / 4;
    for (int k = 0; k < nw; k++) begin
      @(negedge clk);
      w = {fb[4*k], fb[4*k+1], fb[4*k+2], fb[4*k+3]};
      in_valid = 1; in_sof = (k == 0); in_eof = (k == nw - 1); in_data = w;
      pkt_release = rel_first && (k == 0);
      #1;
      if (exp_acc) begin
        chk("R1 wr_en", int'(fifo_wr_en), 1);
        chk("R1 wr_addr", int'(fifo_wr_addr), k);
        chk("R1 wr_data", int'(fifo_wr_data == w), 1);
      end else begin
        chk("R8 dropped word not written", int'(fifo_wr_en), 0);
      end
    end
    @(negedge clk);
    in_valid = 0; in_sof = 0; in_eof = 0; pkt_release = 0;
    #1;
  endtask

  task automatic check_result();
    if (e_ip && e_bad) begin
      chk("R6 csum_err", int'(csum_err), 1);
      chk("R6 flush", int'(fifo_flush), 1);
      chk("R6 info_valid low", int'(info_valid), 0);
      chk("R6 fields zero", int'(info_proto) + int'(info_data_len) + int'(info_ip_hlen), 0);
    end else begin
      chk("R6 no csum_err", int'(csum_err), 0);
      chk("R7 info_valid", int'(info_valid), 1);
      chk("R2 proto", int'(info_proto), e_proto);
      chk(e_ip ? "R3 ip_hlen" : "R5 ip_hlen", int'(info_ip_hlen), e_iph);
      chk(e_ip ? "R4 l4_hlen" : "R5 l4_hlen", int'(info_l4_hlen), e_l4h);
      chk(e_ip ? "R4 data_len" : "R5 data_len", int'(info_data_len), e_dlen);
    end
    @(negedge clk); #1;
    chk("R6 strobe one cycle", int'(csum_err) + int'(fifo_flush), 0);
  endtask

  task automatic release_rec();
    @(negedge clk); pkt_release = 1;
    @(negedge clk); pkt_release = 0; #1;
    chk("R7 release clears valid", int'(info_valid), 0);
    chk("R7 release clears fields",
        int'(info_proto) + int'(info_ip_hlen) + int'(info_l4_hlen) + int'(info_data_len), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int sp, sd, sl, prots[3];
    void'($urandom(32'd20240611));
    prots[0] = 6; prots[1] = 17; prots[2] = 1;
    repeat (3) @(negedge clk);
    #1;
    chk("R11 reset wr_en", int'(fifo_wr_en), 0);
    chk("R11 reset info", int'(info_valid) + int'(info_proto) + int'(info_data_len), 0);
    chk("R11 reset flags", int'(csum_err) + int'(fifo_flush) + int'(ovf_flag), 0);
    rst_n = 1;

    build_ip(5, 6, 5, 100, 0);  send_frame(0, 1); check_result(); release_rec();
    build_ip(5, 17, 0, 30, 0);  send_frame(0, 1); check_result(); release_rec();
    build_ip(6, 1, 0, 12, 0);   send_frame(0, 1); check_result(); release_rec();
    build_raw(16'h0806, 60);    send_frame(0, 1); check_result(); release_rec();
    build_raw(16'h8035, 60);    send_frame(0, 1); check_result(); release_rec();
    build_raw(16'h86DD, 64);    send_frame(0, 1); check_result(); release_rec();
    build_ip(15, 6, 15, 40, 0); send_frame(0, 1); check_result(); release_rec();
    build_ip(15, 17, 0, 0, 1);  send_frame(0, 1); check_result();
    chk("R6 nothing held after error", int'(info_valid), 0);

    build_ip(5, 6, 8, 50, 0); send_frame(0, 1); check_result();
    sp = e_proto; sd = e_dlen; sl = e_l4h;
    chk("R9 ovf low before drop", int'(ovf_flag), 0);
    build_ip(7, 17, 0, 20, 0); send_frame(0, 0);
    chk("R9 ovf set", int'(ovf_flag), 1);
    chk("R8 record kept proto", int'(info_proto), sp);
    chk("R8 record kept len", int'(info_data_len), sd);
    chk("R8 record kept l4", int'(info_l4_hlen), sl);
    build_ip(5, 17, 0, 70, 0); send_frame(1, 1); check_result();
    chk("R10 release with start keeps ovf", int'(ovf_flag), 1);
    release_rec();

    for (int i = 0; i < 60; i++) begin
      int kind;
      kind = rnd(0, 5);
      if (kind == 4) build_raw(rnd(0, 1) ? 16'h0806 : 16'h9000, rnd(60, 120));
      else build_ip(rnd(5, 15), prots[rnd(0, 2)], rnd(5, 15), rnd(0, 300), kind == 5);
      send_frame(0, 1); check_result();
      chk("R9 ovf stays", int'(ovf_flag), 1);
      if (info_valid) release_rec();
    end
    summary();
  end
endmodule